// File: doc/BRIEF.md
# Two-Channel Trigger Timestamp Capture

This block stamps the arrival of asynchronous trigger edges with the time kept by the surrounding timing logic. The time has two parts. The whole-second part is the real-time-clock value supplied on an input. The fractional part is an internal count of 100 ns ticks of the 10 MHz reference clock, which restarts on every one-pulse-per-second strobe. There are two trigger channels and they are fully independent. Each channel is single-shot. A host command arms it, the first rising trigger edge after arming is recorded, and the stamp is then held with a valid flag until the host clears or re-arms the channel.

Each trigger line passes through a synchronizer and a rising-edge detector. This path delays detection by a fixed number of cycles. The block removes that delay by sending the (seconds, tick) pair through a delay line of the same depth. The stored stamp therefore names the cycle in which the raw line was first sampled high, not the later cycle in which the edge was detected.

The stamp outputs carry no back-pressure. A valid flag stays high and the stamp stays frozen for as long as the host needs, so no ready signal exists. A result is consumed by a clear or a re-arm strobe. The RTC is expected to move to its new value in the cycle after the PPS strobe.

Top module: `trig_stamp`

## Requirements
- R1: The tick count advances by one each clock cycle. From TICKS-1 it wraps to 0 when no PPS strobe is present.
- R2: A PPS strobe forces the tick count to 0 in the following cycle, whatever its current value.
- R3: A stamp equals the `rtc_sec` value and tick count present in the cycle whose closing clock edge first samples the raw trigger high. Its valid flag is visible after the second clock edge that follows that sampling edge.
- R4: A trigger edge on a channel that is not armed is not recorded. Arming afterwards does not make it valid.
- R5: Only a low-to-high transition is recorded. A trigger line that is already high when the channel is armed produces no stamp until it falls and rises again.
- R6: Only the first edge after arming is recorded. Later edges leave the stamp and valid flag unchanged.
- R7: An arm strobe arms the channel and drops its valid flag after one edge. A clear strobe drops the flag and disarms the channel. When both strobes are present in the same cycle, clear wins.
- R8: A trigger sampled in the same cycle as a PPS strobe is stamped with the seconds value from before the rollover and the tick count from before the restart.
- R9: Capture, arming and clearing on one channel never change the other channel's outputs.
- R10: After reset, both valid flags are 0, all stamps are 0 and both channels are disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock; one cycle is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps | input | 1 | One-cycle strobe marking the start of a second |
| rtc_sec | input | SEC_W | Current whole-second value; it steps in the cycle after `pps` |
| trig_raw | input | NCH | Asynchronous trigger lines, one per channel |
| arm | input | NCH | Per-channel one-cycle arm command |
| clr | input | NCH | Per-channel one-cycle clear command |
| ts_valid | output | NCH | Per-channel stamp-held flag |
| ts_sec | output | NCH*SEC_W | Seconds part of each stamp, channel 0 in the low bits |
| ts_sub | output | NCH*CW | Tick part of each stamp, CW = clog2(TICKS), channel 0 in the low bits |

## Verification
Suppose a trigger is raised just before clock edge k. Its stamp becomes visible after edge k+2. The bench therefore checks at the falling edge after k+1 that the flag is still low, and at the falling edge after k+2 that it is high and holds the expected values. Arm and clear take effect after a single edge. A PPS restart appears in the tick captured by a trigger raised in the cycle right after the strobe. All inputs change and all outputs are read on falling edges, so each result is read exactly in the cycle its latency allows. The expected tick is taken from a counter kept in the bench, which follows R1 and R2.

// File: rtl/trig_stamp_pkg.sv
package trig_stamp_pkg;

  // Per-cycle action a capture channel takes, in priority order.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_ARM   = 2'd2,
    ACT_TAKE  = 2'd3
  } chan_act_e;

  function automatic chan_act_e pick_action(input logic clr_i, input logic arm_i,
                                            input logic armed_i, input logic hit_i);
    if (clr_i)               return ACT_CLEAR;
    else if (arm_i)          return ACT_ARM;
    else if (armed_i && hit_i) return ACT_TAKE;
    else                     return ACT_HOLD;
  endfunction

endpackage

// File: rtl/trig_stamp_subsec.sv
module trig_stamp_subsec #(
  parameter int TICKS = 10_000_000,
  localparam int CW   = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pps,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (pps)         cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  // R1: the count stays inside one second's worth of ticks
  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);

  // R1: one tick per cycle between restarts
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pps && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

  // R2: the strobe restarts the count
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n) pps |=> (cnt == '0));

endmodule

// File: rtl/trig_stamp_sync.sv
module trig_stamp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      hist  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      hist  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~hist;

  // R5: a detected edge lasts exactly one cycle, so a held-high line fires once
  p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise);

endmodule

// File: rtl/trig_stamp_chan.sv
module trig_stamp_chan
  import trig_stamp_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int CW    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             clr,
  input  logic             hit,
  input  logic [SEC_W-1:0] cap_sec,
  input  logic [CW-1:0]    cap_sub,
  output logic             valid,
  output logic [SEC_W-1:0] sec,
  output logic [CW-1:0]    sub
);

  logic      armed;
  chan_act_e act;

  assign act = pick_action(clr, arm, armed, hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      valid <= 1'b0;
      sec   <= '0;
      sub   <= '0;
    end else begin
      unique case (act)
        ACT_CLEAR: begin
          armed <= 1'b0;
          valid <= 1'b0;
        end
        ACT_ARM: begin
          armed <= 1'b1;
          valid <= 1'b0;
        end
        ACT_TAKE: begin
          armed <= 1'b0;
          valid <= 1'b1;
          sec   <= cap_sec;
          sub   <= cap_sub;
        end
        default: ;
      endcase
    end
  end

  // R4: a stamp only appears on an armed channel that saw an edge
  p_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($past(armed) && $past(hit)));

  // R6: a held stamp does not move until a command arrives
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !arm && !clr) |=> (valid && $stable(sec) && $stable(sub)));

  // R7: arming drops the flag and leaves the channel armed
  p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !clr) |=> (!valid && armed));

  // R7: clearing drops the flag and disarms, even with arm present
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!valid && !armed));

endmodule

// File: rtl/trig_stamp.sv
module trig_stamp #(
  parameter int NCH         = 2,
  parameter int SEC_W       = 32,
  parameter int TICKS       = 10_000_000,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(TICKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pps,
  input  logic [SEC_W-1:0]     rtc_sec,
  input  logic [NCH-1:0]       trig_raw,
  input  logic [NCH-1:0]       arm,
  input  logic [NCH-1:0]       clr,
  output logic [NCH-1:0]       ts_valid,
  output logic [NCH*SEC_W-1:0] ts_sec,
  output logic [NCH*CW-1:0]    ts_sub
);

  logic [CW-1:0] tick;

  trig_stamp_subsec #(.TICKS(TICKS)) u_subsec (
    .clk   (clk),
    .rst_n (rst_n),
    .pps   (pps),
    .cnt   (tick)
  );

  // Time pair delayed by the synchronizer depth, so that a detected edge
  // meets the time of the cycle in which its line was first sampled.
  logic [SEC_W-1:0] dl_sec [SYNC_STAGES];
  logic [CW-1:0]    dl_sub [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dl_sec[g] <= '0;
        dl_sub[g] <= '0;
      end else if (g == 0) begin
        dl_sec[g] <= rtc_sec;
        dl_sub[g] <= tick;
      end else begin
        dl_sec[g] <= dl_sec[(g == 0) ? 0 : g-1];
        dl_sub[g] <= dl_sub[(g == 0) ? 0 : g-1];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;

    trig_stamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (trig_raw[c]),
      .rise  (hit)
    );

    trig_stamp_chan #(.SEC_W(SEC_W), .CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm[c]),
      .clr     (clr[c]),
      .hit     (hit),
      .cap_sec (dl_sec[SYNC_STAGES-1]),
      .cap_sub (dl_sub[SYNC_STAGES-1]),
      .valid   (ts_valid[c]),
      .sec     (ts_sec[c*SEC_W +: SEC_W]),
      .sub     (ts_sub[c*CW +: CW])
    );

    // R9: commands on other channels never drop this channel's stamp
    p_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_valid[c] && !arm[c] && !clr[c]) |=> ts_valid[c]);
  end

endmodule

// File: tb/test_trig_stamp.sv
module test_trig_stamp;

  localparam int NCH   = 2;
  localparam int SEC_W = 32;
  localparam int TICKS = 40;
  localparam int CW    = $clog2(TICKS);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 pps = 1'b0;
  logic [SEC_W-1:0]     rtc_sec = 32'd1_700_000_000;
  logic [NCH-1:0]       trig_raw = '0;
  logic [NCH-1:0]       arm = '0;
  logic [NCH-1:0]       clr = '0;
  logic [NCH-1:0]       ts_valid;
  logic [NCH*SEC_W-1:0] ts_sec;
  logic [NCH*CW-1:0]    ts_sub;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  trig_stamp #(.NCH(NCH), .SEC_W(SEC_W), .TICKS(TICKS), .SYNC_STAGES(2)) i_trig_stamp (
    .clk      (clk),
    .rst_n    (rst_n),
    .pps      (pps),
    .rtc_sec  (rtc_sec),
    .trig_raw (trig_raw),
    .arm      (arm),
    .clr      (clr),
    .ts_valid (ts_valid),
    .ts_sec   (ts_sec),
    .ts_sub   (ts_sub)
  );

  // Bench model of the tick count (R1, R2)
  always @(posedge clk) begin
    if (!rst_n)               m_cnt <= 0;
    else if (pps)             m_cnt <= 0;
    else if (m_cnt == TICKS-1) m_cnt <= 0;
    else                      m_cnt <= m_cnt + 1;
  end

  function automatic logic [SEC_W-1:0] sec_of(int ch);
    return ts_sec[ch*SEC_W +: SEC_W];
  endfunction

  function automatic logic [CW-1:0] sub_of(int ch);
    return ts_sub[ch*CW +: CW];
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_stamp(input int ch, input logic [SEC_W-1:0] xs, input int xsub,
                             input string tag);
    check(ts_valid[ch] == 1'b1, {tag, " valid"}, ts_valid[ch], 1);
    check(sec_of(ch) == xs, {tag, " sec"}, sec_of(ch), xs);
    check(sub_of(ch) == CW'(xsub), {tag, " sub"}, sub_of(ch), xsub);
  endtask

  task automatic arm_ch(input int ch);
    @(negedge clk); arm[ch] = 1'b1;
    @(negedge clk); arm[ch] = 1'b0;
    check(ts_valid[ch] == 1'b0, "R7 arm drops valid", ts_valid[ch], 0);
  endtask

  // Raise trigger at the current falling edge. mode 0: expect capture with
  // model time; 1: expect capture with given time; 2: expect no change.
  task automatic stamp(input int ch, input int mode, input logic [SEC_W-1:0] gsec,
                       input int gsub, input string tag);
    logic [SEC_W-1:0] xs;
    int xsub;
    logic v0;
    logic [SEC_W-1:0] s0;
    logic [CW-1:0] u0;
    v0 = ts_valid[ch]; s0 = sec_of(ch); u0 = sub_of(ch);
    xs = (mode == 1) ? gsec : rtc_sec;
    xsub = (mode == 1) ? gsub : m_cnt;
    trig_raw[ch] = 1'b1;
    @(negedge clk);
    trig_raw[ch] = 1'b0;
    if (pps) begin
      pps = 1'b0;
      rtc_sec = rtc_sec + 1;
    end
    @(negedge clk);
    if (mode != 2) check(ts_valid[ch] == 1'b0, {tag, " R3 not yet valid"}, ts_valid[ch], 0);
    @(negedge clk);
    if (mode == 2) begin
      check(ts_valid[ch] == v0, {tag, " valid unchanged"}, ts_valid[ch], v0);
      check(sec_of(ch) == s0 && sub_of(ch) == u0, {tag, " stamp unchanged"},
            {sec_of(ch), sub_of(ch)}, {s0, u0});
    end else begin
      check_stamp(ch, xs, xsub, tag);
    end
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) begin
      check(ts_valid[c] == 1'b0, "R10 reset valid", ts_valid[c], 0);
      check(sec_of(c) == '0 && sub_of(c) == '0, "R10 reset stamp", sec_of(c), 0);
    end
  endtask

  task automatic t_unarmed();
    @(negedge clk);
    stamp(1, 2, '0, 0, "R4 unarmed edge");
    arm_ch(1);
    repeat (3) @(negedge clk);
    check(ts_valid[1] == 1'b0, "R4 arming later gives no stamp", ts_valid[1], 0);
  endtask

  task automatic t_basic();
    arm_ch(0);
    repeat (5) @(negedge clk);
    stamp(0, 0, '0, 0, "R3 basic ch0");
    check(ts_valid[1] == 1'b0, "R9 ch1 untouched by ch0", ts_valid[1], 0);
  endtask

  task automatic t_first_only();
    repeat (3) @(negedge clk);
    stamp(0, 2, '0, 0, "R6 later edge ignored");
  endtask

  task automatic t_indep();
    logic [SEC_W-1:0] s0;
    logic [CW-1:0] u0;
    s0 = sec_of(0); u0 = sub_of(0);
    repeat (7) @(negedge clk);
    rtc_sec = rtc_sec + 5;
    stamp(1, 0, '0, 0, "R9 ch1 own stamp");
    check(sec_of(0) == s0 && sub_of(0) == u0 && ts_valid[0], "R9 ch0 kept",
          sub_of(0), u0);
  endtask

  task automatic t_cmds();
    arm_ch(0);
    check(ts_valid[1] == 1'b1, "R9 arm ch0 leaves ch1", ts_valid[1], 1);
    @(negedge clk); clr[1] = 1'b1;
    @(negedge clk); clr[1] = 1'b0;
    check(ts_valid[1] == 1'b0, "R7 clear drops valid", ts_valid[1], 0);
    stamp(1, 2, '0, 0, "R7 cleared channel disarmed");
    @(negedge clk); clr[0] = 1'b1; arm[0] = 1'b1;
    @(negedge clk); clr[0] = 1'b0; arm[0] = 1'b0;
    stamp(0, 2, '0, 0, "R7 clear wins over arm");
  endtask

  task automatic t_level();
    @(negedge clk); trig_raw[0] = 1'b1;
    repeat (4) @(negedge clk);
    arm[0] = 1'b1;
    @(negedge clk); arm[0] = 1'b0;
    repeat (5) @(negedge clk);
    check(ts_valid[0] == 1'b0, "R5 held-high line not captured", ts_valid[0], 0);
    trig_raw[0] = 1'b0;
    repeat (3) @(negedge clk);
    stamp(0, 0, '0, 0, "R5 fresh rise captured");
  endtask

  task automatic t_wrap();
    arm_ch(0);
    arm_ch(1);
    @(negedge clk);
    while (m_cnt != TICKS-1) @(negedge clk);
    stamp(0, 1, rtc_sec, TICKS-1, "R1 last tick");
    @(negedge clk);
    while (m_cnt != TICKS-1) @(negedge clk);
    @(negedge clk);
    stamp(1, 1, rtc_sec, 0, "R1 wrap to zero");
  endtask

  task automatic t_pps_restart();
    arm_ch(0);
    repeat (9) @(negedge clk);
    pps = 1'b1;
    @(negedge clk); pps = 1'b0; rtc_sec = rtc_sec + 1;
    stamp(0, 1, rtc_sec, 0, "R2 restart on pps");
  endtask

  task automatic t_pps_same();
    logic [SEC_W-1:0] old_sec;
    int old_cnt;
    arm_ch(1);
    repeat (13) @(negedge clk);
    old_sec = rtc_sec;
    old_cnt = m_cnt;
    pps = 1'b1;
    stamp(1, 1, old_sec, old_cnt, "R8 edge with pps");
    check(rtc_sec == old_sec + 1, "R8 rtc stepped after", rtc_sec, old_sec + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_basic();
    t_first_only();
    t_indep();
    t_cmds();
    t_level();
    t_wrap();
    t_pps_restart();
    t_pps_same();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule